// File: doc/BRIEF.md
# Multi-Rate Enable Strobe Generator

This block paces slower logic from a single fast system clock. A binary counter runs from zero up to a terminal value taken from an input port, then starts again at zero. Each of the low counter bits is treated as a level signal, and each level passes through its own rising-edge detector. The result is a set of strobes, each exactly one clock wide.

Consumers use a strobe as a clock enable on ordinary flip-flops in the same clock domain. No gated or derived clock is ever produced. With the terminal value set to all ones, strobe `k` fires once every 2^(k+1) clocks. Lower terminal values give shorter and irregular patterns, for example when a data rate other than a power of two is wanted.

Changing the terminal value takes effect on the next clock. If the counter is already above the new value, it returns to zero.

Top module: `rate_strobe_gen`

## Requirements
- R1: While `rst_i` is high the counter is held at 0 and every strobe is 0. No strobe appears in the first clock after reset is released.
- R2: The counter advances by one on each clock. After it equals `term_i` it becomes 0 on the next clock, so with a steady `term_i = n` it repeats every n+1 clocks.
- R3: `strb_o[k]` goes high for exactly one clock when count bit `k` changes from 0 to 1. The strobe is high in the clock after the edge on which that bit rose, which is one cycle of latency.
- R4: A count bit that stays high for several clocks produces only one strobe. With `term_i = 7`, bit 2 is high for 4 clocks per period yet gives only 8 strobes in 64 clocks.
- R5: With `term_i` all ones (7 at the default width of 3), `strb_o[0]`, `strb_o[1]` and `strb_o[2]` each pulse periodically. They fire every 2, 4 and 8 clocks, that is 32, 16 and 8 strobes in any 64 consecutive clocks.
- R6: If `term_i` is lowered below the present count, the counter returns to 0 on the next clock.
- R7: With `term_i = 0` the counter stays at 0 and no strobe is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; all state is on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| term_i | input | CNT_W | Terminal count; the counter wraps after reaching it |
| strb_o | output | STRB_N | One-clock enable strobes, bit k from count bit k |

## Verification
On every cycle, the assertions check the counter's step and wrap rule, the reset state, and that every strobe is one clock wide. They also check that a strobe is always preceded by a rising edge of its count bit.

Only the bench's scenarios can show that strobes are not missed, that the periods at the all-ones setting are correct, and that a held level gives one strobe instead of many. The same holds for the effect of lowering the terminal value while the counter is high, and for the silence at a terminal value of zero. The bench covers these by comparing every cycle against its own model and by counting strobes over fixed windows.

// File: rtl/rsg_pkg.sv
package rsg_pkg;

  localparam int DEF_CNT_W  = 3;
  localparam int DEF_STRB_N = 3;

  // Number of clocks between strobes of bit k when the counter runs full range.
  function automatic int strobe_period(input int k);
    return 1 << (k + 1);
  endfunction

endpackage

// File: rtl/rsg_counter.sv
module rsg_counter #(
  parameter int CNT_W = rsg_pkg::DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [CNT_W-1:0] term_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;

  // Using >= rather than == lets a lowered terminal value pull the count back at once.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
    end else if (cnt_q >= term_i) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/rsg_edge.sv
module rsg_edge (
  input  logic clk_i,
  input  logic rst_i,
  input  logic lvl_i,
  output logic pulse_o
);

  logic prev_q;
  logic pulse_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      prev_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      prev_q  <= lvl_i;
      pulse_q <= lvl_i & ~prev_q;
    end
  end

  assign pulse_o = pulse_q;

endmodule

// File: rtl/rate_strobe_gen.sv
module rate_strobe_gen #(
  parameter int CNT_W  = rsg_pkg::DEF_CNT_W,
  parameter int STRB_N = rsg_pkg::DEF_STRB_N
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [CNT_W-1:0]  term_i,
  output logic [STRB_N-1:0] strb_o
);

  localparam int N_USED = (STRB_N < CNT_W) ? STRB_N : CNT_W;

  logic [CNT_W-1:0] cnt_w;

  rsg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .term_i (term_i),
    .cnt_o  (cnt_w)
  );

  for (genvar k = 0; k < STRB_N; k++) begin : g_strb
    if (k < N_USED) begin : g_live
      rsg_edge u_edge (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .lvl_i   (cnt_w[k]),
        .pulse_o (strb_o[k])
      );
    end else begin : g_tie
      assign strb_o[k] = 1'b0;
    end
  end

endmodule

// File: rtl/rsg_chk.sv
module rsg_chk #(
  parameter int CNT_W  = rsg_pkg::DEF_CNT_W,
  parameter int STRB_N = rsg_pkg::DEF_STRB_N
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic [CNT_W-1:0]  term_i,
  input logic [CNT_W-1:0]  cnt_w,
  input logic [STRB_N-1:0] strb_o
);

  localparam int N_USED = (STRB_N < CNT_W) ? STRB_N : CNT_W;

  // R1
  p_reset_r1: assert property (@(posedge clk_i) rst_i |=> (cnt_w == '0 && strb_o == '0));

  // R2
  p_step_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (cnt_w < term_i) |=> (cnt_w == $past(cnt_w) + 1'b1));

  // R2, R6
  p_wrap_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (cnt_w >= term_i) |=> (cnt_w == '0));

  for (genvar k = 0; k < N_USED; k++) begin : g_bit
    // R3: a strobe never lasts past one clock.
    p_single_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      strb_o[k] |=> !strb_o[k]);
    // R4: a strobe is always preceded by a rising edge of its count bit.
    p_rise_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      strb_o[k] |-> ($past(cnt_w[k]) && !$past(cnt_w[k], 2)));
  end

endmodule

bind rate_strobe_gen rsg_chk #(.CNT_W(CNT_W), .STRB_N(STRB_N)) u_chk (
  .clk_i  (clk_i),
  .rst_i  (rst_i),
  .term_i (term_i),
  .cnt_w  (cnt_w),
  .strb_o (strb_o)
);

// File: tb/sim_rate_strobe_gen.sv
module sim_rate_strobe_gen;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W  = 3;
  localparam int STRB_N = 3;

  logic              clk = 1'b0;
  logic              rst;
  logic [CNT_W-1:0]  term;
  logic [STRB_N-1:0] strb;

  int    n_checks = 0;
  int    n_fail   = 0;
  string tag      = "R1";
  bit    done     = 1'b0;

  logic [STRB_N-1:0] exp_q[$];
  logic [CNT_W-1:0]  m_cnt  = '0;
  logic [CNT_W-1:0]  m_prev = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rate_strobe_gen #(.CNT_W(CNT_W), .STRB_N(STRB_N)) u0 (
    .clk_i  (clk),
    .rst_i  (rst),
    .term_i (term),
    .strb_o (strb)
  );

  // Reference model: pushes the expected strobe vector after each edge.
  always @(posedge clk) begin
    logic [STRB_N-1:0] e;
    if (rst) begin
      e = '0; m_cnt = '0; m_prev = '0;
    end else begin
      e = m_cnt[STRB_N-1:0] & ~m_prev[STRB_N-1:0];
      m_prev = m_cnt;
      m_cnt  = (m_cnt >= term) ? '0 : m_cnt + 1'b1;
    end
    exp_q.push_back(e);
  end

  // Monitor: compares away from the active edge.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [STRB_N-1:0] e;
      e = exp_q.pop_front();
      n_checks++;
      if (strb !== e) begin
        n_fail++;
        $display("FAIL %s strobes: actual %b expected %b", tag, strb, e);
      end
    end
  end

  task automatic check_eq(input string t, input int act, input int expv);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", t, act, expv);
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Counts strobes on each bit over n clocks.
  task automatic count_strobes(input int n, output int c0, output int c1, output int c2);
    c0 = 0; c1 = 0; c2 = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      c0 += int'(strb[0]); c1 += int'(strb[1]); c2 += int'(strb[2]);
    end
  endtask

  initial begin
    int c0, c1, c2;
    rst = 1'b1; term = 3'd7;
    run(4);
    #1 check_eq("R1 strobes in reset", int'(strb), 0);
    @(negedge clk) rst = 1'b0;
    @(negedge clk); #1 check_eq("R1 first clock after reset", int'(strb), 0);

    tag = "R5";
    run(10);
    count_strobes(64, c0, c1, c2);
    check_eq("R5 strobe0 count in 64", c0, 32);
    check_eq("R5 strobe1 count in 64", c1, 16);
    check_eq("R4 strobe2 count in 64", c2, 8);

    tag = "R2";
    @(negedge clk) term = 3'd5;
    run(30);
    tag = "R3";
    @(negedge clk) term = 3'd3;
    run(20);

    tag = "R6";
    @(negedge clk) term = 3'd7;
    while (m_cnt != 3'd6) @(negedge clk);
    term = 3'd2;
    run(20);

    tag = "R7";
    @(negedge clk) term = 3'd0;
    run(4);
    count_strobes(24, c0, c1, c2);
    check_eq("R7 strobe count with term 0", c0 + c1 + c2, 0);

    tag = "R2";
    @(negedge clk) term = 3'd1;
    run(20);

    tag = "R1";
    @(negedge clk) rst = 1'b1;
    run(3);
    #1 check_eq("R1 strobes in mid-run reset", int'(strb), 0);
    @(negedge clk) rst = 1'b0; term = 3'd7;
    run(20);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    end
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule